// File: doc/BRIEF.md
# Three-Lane Block FIR Filter with Serial Wrapper

This block is a three-tap FIR filter that works on whole blocks of three samples. A serial sample stream enters one sample per sample-enable. An input converter gathers the samples into groups of three and gives each complete group to a core with three multiply-add lanes. Each lane computes one output of the block. It uses the current group and the two newest samples of the previous group, which are kept in block-rate registers. An output converter queues the three results and hands them back out as a serial stream, one per sample-enable, in sample order.

The core runs once per block. The sample rate can therefore be three times the rate at which any one lane evaluates, and each lane's path stays one multiply followed by two adds. Coefficients are static signed inputs that are held between resets. The result is carried at full precision, with no rounding and no saturation.

Top module: `fir3_par3`

## Requirements
- R1: The first lane of each block outputs y(3k) = a·x(3k) + b·x(3k−1) + c·x(3k−2).
- R2: The second lane outputs y(3k+1) = a·x(3k+1) + b·x(3k) + c·x(3k−1).
- R3: The third lane outputs y(3k+2) = a·x(3k+2) + b·x(3k+1) + c·x(3k).
- R4: The input converter accepts one sample on each cycle with `smp_en_i` high. After every third accepted sample it raises an internal block strobe, with the lanes ordered oldest sample first. The core result is valid on the cycle after that strobe.
- R5: The samples x(3k−2) and x(3k−1) come from the previous block. After reset they read as zero, so the first outputs behave as if zeros preceded the stream.
- R6: Outputs leave in sample order y(n), y(n+1), and so on. There is at most one per cycle, and only on a cycle that follows a cycle with `smp_en_i` high, flagged by `y_vld_o`. `y_o` holds its value while `y_vld_o` is low. The output queue never holds more than two blocks.
- R7: While the asynchronous active-low reset is asserted, `y_o` is zero and `y_vld_o` is low.
- R8: A value on `x_i` during a cycle with `smp_en_i` low has no effect on any output.
- R9: Samples and coefficients are 16-bit two's complement. `y_o` is 34-bit two's complement and holds the exact sum, including the extreme case where every operand is −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample enable: accept `x_i` and advance the output stream |
| x_i | input | 16 | Serial input sample, signed |
| coef_a_i | input | 16 | Coefficient on the newest sample, signed |
| coef_b_i | input | 16 | Coefficient on the one-sample-old sample, signed |
| coef_c_i | input | 16 | Coefficient on the two-sample-old sample, signed |
| y_o | output | 34 | Serial output sample, signed |
| y_vld_o | output | 1 | `y_o` carries a new output sample this cycle |

## Verification
An impulse straight after reset puts each coefficient alone on successive outputs. That separates the three lanes and shows whether the taps carried from the previous block are wired to the right lane. A step and a run of alternating full-scale values with extreme coefficients test the sums and the full-precision width, where a truncated or unsigned product would show. A random stream with gapped sample enables, and garbage on `x_i` during the gaps, checks that grouping, queueing and output order hold when samples arrive irregularly. Each phase starts from reset, so the zeroed history is exercised each time.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int unsigned LANES   = 3;
  localparam int unsigned GUARD_W = 2;
endpackage

// File: rtl/fir3_s2p.sv
module fir3_s2p #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic [DW-1:0]              x_i,
  output logic [LANES-1:0][DW-1:0]   blk_o,
  output logic                       vld_o
);
  localparam int unsigned CW = $clog2(LANES);

  logic [LANES-2:0][DW-1:0] sh_q;
  logic [CW-1:0]            phase_q;
  logic                     last;

  assign last = (phase_q == CW'(LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      phase_q <= '0;
      blk_o   <= '0;
      vld_o   <= 1'b0;
    end else begin
      vld_o <= en_i && last;
      if (en_i) begin
        sh_q[0] <= x_i;
        for (int i = 1; i < LANES - 1; i++) sh_q[i] <= sh_q[i-1];
        phase_q <= last ? '0 : phase_q + 1'b1;
        if (last) begin
          // oldest sample in lane 0
          blk_o[LANES-1] <= x_i;
          for (int j = 0; j < LANES - 1; j++) blk_o[j] <= sh_q[LANES-2-j];
        end
      end
    end
  end
endmodule

// File: rtl/fir3_core.sv
module fir3_core #(
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = 16,
  parameter int unsigned OW    = DW + CW + 2,
  parameter int unsigned LANES = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  logic [LANES-1:0][DW-1:0]   blk_i,
  input  logic [CW-1:0]              coef_a_i,
  input  logic [CW-1:0]              coef_b_i,
  input  logic [CW-1:0]              coef_c_i,
  output logic [LANES-1:0][OW-1:0]   y_o,
  output logic                       vld_o
);
  localparam int unsigned PW = DW + CW;

  logic [DW-1:0] hist_old_q, hist_new_q;
  logic [DW-1:0] ext [LANES+2];
  logic [LANES-1:0][OW-1:0] sum;

  always_comb begin
    ext[0] = hist_old_q;
    ext[1] = hist_new_q;
    for (int j = 0; j < LANES; j++) ext[j+2] = blk_i[j];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [PW-1:0] pa, pb, pc;
    assign pa = $signed(coef_a_i) * $signed(ext[g+2]);
    assign pb = $signed(coef_b_i) * $signed(ext[g+1]);
    assign pc = $signed(coef_c_i) * $signed(ext[g]);
    assign sum[g] = {{(OW-PW){pa[PW-1]}}, pa} + {{(OW-PW){pb[PW-1]}}, pb}
                  + {{(OW-PW){pc[PW-1]}}, pc};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_old_q <= '0;
      hist_new_q <= '0;
      y_o        <= '0;
      vld_o      <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        hist_old_q <= blk_i[LANES-2];
        hist_new_q <= blk_i[LANES-1];
        y_o        <= sum;
      end
    end
  end
endmodule

// File: rtl/fir3_p2s.sv
module fir3_p2s #(
  parameter int unsigned OW    = 34,
  parameter int unsigned LANES = 3,
  parameter int unsigned QD    = 2 * LANES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic [LANES-1:0][OW-1:0]   blk_i,
  input  logic                       en_i,
  output logic [OW-1:0]              y_o,
  output logic                       vld_o,
  output logic [$clog2(QD+1)-1:0]    fill_o
);
  localparam int unsigned FW = $clog2(QD + 1);

  logic [QD-1:0][OW-1:0] q_q, q_d;
  logic [FW-1:0]         cnt_d;
  logic                  pop;

  assign pop = en_i && (fill_o != '0);

  always_comb begin
    q_d   = q_q;
    cnt_d = fill_o;
    if (pop) begin
      for (int i = 0; i < QD - 1; i++) q_d[i] = q_q[i+1];
      cnt_d = cnt_d - 1'b1;
    end
    if (load_i) begin
      for (int j = 0; j < LANES; j++)
        if (int'(cnt_d) + j < QD) q_d[int'(cnt_d) + j] = blk_i[j];
      cnt_d = cnt_d + FW'(LANES);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      fill_o <= '0;
      y_o    <= '0;
      vld_o  <= 1'b0;
    end else begin
      q_q    <= q_d;
      fill_o <= cnt_d;
      vld_o  <= pop;
      if (pop) y_o <= q_q[0];
    end
  end
endmodule

// File: rtl/fir3_par3.sv
module fir3_par3 #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned OW = DW + CW + fir3_pkg::GUARD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_en_i,
  input  logic [DW-1:0] x_i,
  input  logic [CW-1:0] coef_a_i,
  input  logic [CW-1:0] coef_b_i,
  input  logic [CW-1:0] coef_c_i,
  output logic [OW-1:0] y_o,
  output logic          y_vld_o
);
  localparam int unsigned LANES = fir3_pkg::LANES;
  localparam int unsigned QD    = 2 * LANES;
  localparam int unsigned FW    = $clog2(QD + 1);

  logic [LANES-1:0][DW-1:0] s2p_blk;
  logic                     s2p_vld;
  logic [LANES-1:0][OW-1:0] core_y;
  logic                     core_vld;
  logic [FW-1:0]            p2s_fill;

  fir3_s2p #(.DW(DW), .LANES(LANES)) i_s2p (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(smp_en_i), .x_i(x_i),
    .blk_o (s2p_blk), .vld_o(s2p_vld)
  );

  fir3_core #(.DW(DW), .CW(CW), .OW(OW), .LANES(LANES)) i_core (
    .clk_i (clk_i), .rst_ni(rst_ni), .vld_i(s2p_vld), .blk_i(s2p_blk),
    .coef_a_i(coef_a_i), .coef_b_i(coef_b_i), .coef_c_i(coef_c_i),
    .y_o   (core_y), .vld_o(core_vld)
  );

  fir3_p2s #(.OW(OW), .LANES(LANES), .QD(QD)) i_p2s (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(core_vld), .blk_i(core_y),
    .en_i  (smp_en_i), .y_o(y_o), .vld_o(y_vld_o), .fill_o(p2s_fill)
  );
endmodule

// File: rtl/fir3_par3_chk.sv
module fir3_par3_chk #(
  parameter int unsigned OW = 34,
  parameter int unsigned QD = 6,
  parameter int unsigned FW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_en_i,
  input logic          s2p_vld,
  input logic          core_vld,
  input logic [FW-1:0] p2s_fill,
  input logic [OW-1:0] y_o,
  input logic          y_vld_o
);
  // R4
  strobe_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2p_vld |-> $past(smp_en_i));
  // R4
  core_follows_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2p_vld |=> core_vld);
  // R4
  core_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_vld |-> $past(s2p_vld));
  // R6
  out_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_vld_o |-> $past(smp_en_i));
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_vld_o |-> $stable(y_o));
  // R6
  fill_within_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p2s_fill <= FW'(QD));
endmodule

bind fir3_par3 fir3_par3_chk #(.OW(OW), .QD(QD), .FW(FW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_en_i(smp_en_i), .s2p_vld(s2p_vld),
  .core_vld(core_vld), .p2s_fill(p2s_fill), .y_o(y_o), .y_vld_o(y_vld_o)
);

// File: tb/test_fir3_par3.sv
module test_fir3_par3;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               smp_en_i = 1'b0;
  logic signed [15:0] x_i = '0;
  logic signed [15:0] ca = '0, cb = '0, cc = '0;
  logic [33:0]        y_o;
  logic               y_vld_o;

  int     checks = 0, fails = 0, out_idx = 0;
  bit     en_prev = 1'b0, done = 1'b0;
  longint xm1 = 0, xm2 = 0;
  longint exp_q[$];
  string  phase = "";

  always #10 clk_i = ~clk_i;

  fir3_par3 i_fir3_par3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_en_i(smp_en_i), .x_i(x_i),
    .coef_a_i(ca), .coef_b_i(cb), .coef_c_i(cc), .y_o(y_o), .y_vld_o(y_vld_o)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check_out();
    longint e, act;
    string  tag;
    if (!y_vld_o) return;
    checks++;
    act = longint'($signed(y_o));
    if (!en_prev) begin
      fails++;
      $display("FAIL R6 %s: output without sample enable act=%0d exp=none", phase, act);
    end else if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R6 %s: extra output act=%0d exp=none", phase, act);
    end else begin
      e = exp_q.pop_front();
      case (out_idx % 3)
        0: tag = "R1";
        1: tag = "R2";
        default: tag = "R3";
      endcase
      if (out_idx < 3) tag = {tag, " R5"};
      if (act !== e) begin
        fails++;
        $display("FAIL %s R4 R6 R9 %s: out %0d act=%0d exp=%0d", tag, phase, out_idx, act, e);
      end
      out_idx++;
    end
  endtask

  task automatic step(input bit en, input logic signed [15:0] x);
    @(negedge clk_i);
    check_out();
    smp_en_i = en;
    x_i      = x;
    if (en) begin
      exp_q.push_back(longint'(ca) * longint'(x) + longint'(cb) * xm1 + longint'(cc) * xm2);
      xm2 = xm1;
      xm1 = longint'(x);
    end
    en_prev = en;
  endtask

  task automatic do_reset(input logic signed [15:0] a, b, c, input string name);
    @(negedge clk_i);
    rst_ni = 1'b0; smp_en_i = 1'b0; en_prev = 1'b0;
    ca = a; cb = b; cc = c;
    phase = name;
    exp_q.delete(); out_idx = 0; xm1 = 0; xm2 = 0;
    repeat (2) @(negedge clk_i);
    checks++;
    if (y_vld_o !== 1'b0 || y_o !== '0) begin
      fails++;
      $display("FAIL R7 %s: reset outputs act=%0d/%h exp=0/0", phase, y_vld_o, y_o);
    end
    rst_ni = 1'b1;
  endtask

  // keeps enables running so queued outputs drain
  task automatic flush();
    for (int i = 0; i < 9; i++) step(1'b1, 16'sd0);
    for (int i = 0; i < 4; i++) step(1'b0, 16'sh5a5a);
    checks++;
    if (exp_q.size() > 5) begin
      fails++;
      $display("FAIL R6 %s: pending outputs act=%0d exp<=5", phase, exp_q.size());
    end
  endtask

  initial begin
    do_reset(16'sd3, -16'sd5, 16'sd7, "impulse");
    step(1'b1, 16'sd1);
    for (int i = 0; i < 11; i++) step(1'b1, 16'sd0);
    flush();

    do_reset(16'sd11, 16'sd13, -16'sd17, "step");
    for (int i = 0; i < 12; i++) step(1'b1, 16'sd100);
    flush();

    do_reset(-16'sd32768, 16'sd32767, -16'sd32768, "fullscale");
    for (int i = 0; i < 15; i++) step(1'b1, (i % 2 == 0) ? -16'sd32768 : 16'sd32767);
    flush();

    do_reset(-16'sd32768, -16'sd32768, -16'sd32768, "allneg");
    for (int i = 0; i < 9; i++) step(1'b1, -16'sd32768);
    flush();

    // R8: garbage on x_i while the enable is low
    do_reset(16'($urandom), 16'($urandom), 16'($urandom), "gapped");
    for (int i = 0; i < 300; i++) begin
      bit en;
      en = ($urandom % 3) != 0;
      step(en, 16'($urandom));
    end
    flush();

    do_reset(16'sd2, 16'sd0, -16'sd1, "burst");
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 16'(i * 37 - 700));
      if (i % 7 == 3) begin
        step(1'b0, 16'sh7fff);
        step(1'b0, -16'sd1);
      end
    end
    flush();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    report();
  end
endmodule